// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns mailbox traffic into interrupts. The two top words of the address space are mailboxes. The highest address belongs to port 1, and the address one below it belongs to port 0. When one port writes into the other port's mailbox, the block raises an interrupt towards the mailbox owner. The owner then reads its own mailbox, and that read drops the interrupt. The memory array and the message contents live outside this block. The block only looks at each port's enable, write strobe, address and arbitration busy flag.

An access counts when it is sampled on a rising clock edge. An access is either a write (enable high, strobe high) or a read (enable high, strobe low). While a port's arbitration busy flag is high, that port can neither post a message to the other side nor acknowledge its own. The interfaces are plain control pins, because no data stream passes through the block. There is therefore no valid/ready handshake and no back-pressure. Each interrupt output is a registered, active-low level. It changes one clock after the access that causes the change.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, irq0_n and irq1_n are both high.
- R2: A write by port 0 to address 2^AW-1, with busy0 low, drives irq1_n low after the next rising edge.
- R3: A write by port 1 to address 2^AW-2, with busy1 low, drives irq0_n low after the next rising edge.
- R4: A read by port 1 of address 2^AW-1 with busy1 low releases irq1_n to high. A read by port 0 of address 2^AW-2 with busy0 low releases irq0_n to high.
- R5: A port reading the other port's mailbox changes neither interrupt.
- R6: A write into the peer's mailbox made while the writer's busy flag is high does not set the peer's interrupt.
- R7: A read of a port's own mailbox made while that port's busy flag is high does not clear its interrupt.
- R8: When the set and the clear of one interrupt fall in the same cycle, the interrupt ends up asserted (low).
- R9: Accesses with the enable low, accesses to any address other than the two mailboxes, and writes by a port to its own mailbox change neither interrupt.
- R10: With no setting or clearing access, each interrupt output holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en0 | input | 1 | Port 0 access enable |
| we0 | input | 1 | Port 0 strobe: 1 write, 0 read |
| addr0 | input | AW | Port 0 word address |
| busy0 | input | 1 | Port 0 arbitration busy |
| en1 | input | 1 | Port 1 access enable |
| we1 | input | 1 | Port 1 strobe: 1 write, 0 read |
| addr1 | input | AW | Port 1 word address |
| busy1 | input | 1 | Port 1 arbitration busy |
| irq0_n | output | 1 | Interrupt to port 0, active low |
| irq1_n | output | 1 | Interrupt to port 1, active low |

## Verification
Several rules are checked by assertions on every cycle:
- a set leaves the flag asserted, whatever else happens in that cycle;
- a lone clear drops the flag;
- an idle cycle keeps the flag stable;
- a busy writer or reader cannot move the flag it would otherwise touch.

The exact address decode has to be shown by the bench's scenarios. These cover which of the two top addresses belongs to which port, and the fact that reading the peer's box, writing one's own box or accessing an ordinary word does nothing. The bench also checks the one-cycle latency from access to output pin, and that reset returns both lines to inactive while they are asserted.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NPORTS = 2;

  // kind of access seen on one port in one cycle
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic int peer_of(input int p);
    return (p == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] OWN_BOX  = '1,
  parameter logic [AW-1:0] PEER_BOX = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          post,   // qualified write into the peer's mailbox
  output logic          take    // qualified read of the own mailbox
);
  acc_kind_e kind;
  logic      hit_own, hit_peer;

  always_comb begin
    if (!en)     kind = ACC_NONE;
    else if (we) kind = ACC_WRITE;
    else         kind = ACC_READ;
  end

  assign hit_own  = (addr == OWN_BOX);
  assign hit_peer = (addr == PEER_BOX);

  always_comb begin
    post = 1'b0;
    take = 1'b0;
    if (!busy) begin
      post = (kind == ACC_WRITE) && hit_peer;
      take = (kind == ACC_READ)  && hit_own;
    end
  end

  // R9: a disabled port produces no event
  a_r9_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!post && !take));
  // R6 / R7: busy suppresses both events of this port
  a_r6_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!post && !take));
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;   // set has priority over clear
    else if (clr) flag_q <= 1'b0;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag_q));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en0,
  input  logic          we0,
  input  logic [AW-1:0] addr0,
  input  logic          busy0,
  input  logic          en1,
  input  logic          we1,
  input  logic [AW-1:0] addr1,
  input  logic          busy1,
  output logic          irq0_n,
  output logic          irq1_n
);
  localparam logic [AW-1:0] BOX_P1 = '1;                 // highest word
  localparam logic [AW-1:0] BOX_P0 = BOX_P1 - 1'b1;      // one below

  logic          en_v   [NPORTS];
  logic          we_v   [NPORTS];
  logic [AW-1:0] addr_v [NPORTS];
  logic          busy_v [NPORTS];
  logic [NPORTS-1:0] post, take, flag_q;

  assign en_v[0] = en0;   assign en_v[1] = en1;
  assign we_v[0] = we0;   assign we_v[1] = we1;
  assign addr_v[0] = addr0; assign addr_v[1] = addr1;
  assign busy_v[0] = busy0; assign busy_v[1] = busy1;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [AW-1:0] OWN  = (p == 0) ? BOX_P0 : BOX_P1;
    localparam logic [AW-1:0] PEER = (p == 0) ? BOX_P1 : BOX_P0;

    mbox_port_decode #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .en(en_v[p]), .we(we_v[p]), .addr(addr_v[p]), .busy(busy_v[p]),
      .post(post[p]), .take(take[p])
    );

    // flag p is the interrupt towards port p: set by the peer, cleared by p
    mbox_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(post[peer_of(p)]), .clr(take[p]),
      .flag_q(flag_q[p])
    );
  end

  assign irq0_n = ~flag_q[0];
  assign irq1_n = ~flag_q[1];

  // R6: a busy port 0 cannot raise port 1's interrupt
  a_r6_busy_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (busy0 && irq1_n) |=> irq1_n);
  // R7: a busy port 1 cannot drop its own interrupt
  a_r7_busy_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy1 && !irq1_n) |=> !irq1_n);
  // R1: first edge after reset leaves both lines inactive
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (irq0_n && irq1_n));
endmodule

// File: tb/mbox_irq_ctrl_tb.sv
module mbox_irq_ctrl_tb;
  localparam int AW = 12;
  localparam logic [AW-1:0] HI = 12'hFFF;  // port 1 mailbox
  localparam logic [AW-1:0] LO = 12'hFFE;  // port 0 mailbox
  localparam logic [AW-1:0] XX = 12'h123;  // plain word
  localparam int NV = 15;

  // {en0,we0,addr0,busy0, en1,we1,addr1,busy1, exp_irq0_n, exp_irq1_n}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0,1'b0,XX,1'b0, 1'b0,1'b0,XX,1'b0, 1'b1,1'b1}, // R1 idle
    {1'b1,1'b1,HI,1'b0, 1'b0,1'b0,XX,1'b0, 1'b1,1'b0}, // R2 set irq1
    {1'b1,1'b0,HI,1'b0, 1'b0,1'b0,XX,1'b0, 1'b1,1'b0}, // R5 peer box read
    {1'b0,1'b0,XX,1'b0, 1'b1,1'b0,HI,1'b1, 1'b1,1'b0}, // R7 busy read
    {1'b0,1'b0,XX,1'b0, 1'b1,1'b0,HI,1'b0, 1'b1,1'b1}, // R4 clear irq1
    {1'b0,1'b0,XX,1'b0, 1'b1,1'b1,LO,1'b1, 1'b1,1'b1}, // R6 busy write
    {1'b0,1'b0,XX,1'b0, 1'b1,1'b1,LO,1'b0, 1'b0,1'b1}, // R3 set irq0
    {1'b0,1'b0,XX,1'b0, 1'b1,1'b0,LO,1'b0, 1'b0,1'b1}, // R5 peer box read
    {1'b1,1'b1,LO,1'b0, 1'b1,1'b1,XX,1'b0, 1'b0,1'b1}, // R9 own box write
    {1'b0,1'b1,HI,1'b0, 1'b0,1'b0,HI,1'b0, 1'b0,1'b1}, // R9 enable low
    {1'b1,1'b0,LO,1'b0, 1'b1,1'b1,LO,1'b0, 1'b0,1'b1}, // R8 set wins
    {1'b1,1'b0,LO,1'b0, 1'b0,1'b0,XX,1'b0, 1'b1,1'b1}, // R4 clear irq0
    {1'b1,1'b1,HI,1'b0, 1'b1,1'b1,LO,1'b0, 1'b0,1'b0}, // R2 R3 both
    {1'b1,1'b0,LO,1'b0, 1'b1,1'b0,HI,1'b0, 1'b1,1'b1}, // R4 both clear
    {1'b1,1'b1,HI,1'b0, 1'b1,1'b0,HI,1'b0, 1'b1,1'b0}  // R8 set wins
  };
  localparam int VREQ [NV] = '{1,2,5,7,4,6,3,5,9,9,8,4,2,4,8};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en0 = 0, we0 = 0, busy0 = 0, en1 = 0, we1 = 0, busy1 = 0;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic irq0_n, irq1_n;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbox_irq_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .en0(en0), .we0(we0), .addr0(addr0), .busy0(busy0),
    .en1(en1), .we1(we1), .addr1(addr1), .busy1(busy1),
    .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  task automatic check(input string req, input logic e0, input logic e1);
    checks++;
    if (irq0_n !== e0 || irq1_n !== e1) begin
      errors++;
      $display("FAIL %s: irq0_n/irq1_n actual %b%b expected %b%b", req, irq0_n, irq1_n, e0, e1);
    end
  endtask

  task automatic drive(input logic [31:0] v);
    {en0, we0, addr0, busy0, en1, we1, addr1, busy1} = v[31:2];
  endtask

  task automatic step(input logic [31:0] v);
    drive(v);
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b1, 1'b1);           // in reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i]);
      check($sformatf("R%0d vec %0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
    end
    // R10: idle cycles keep irq1 asserted
    for (int i = 0; i < 4; i++) begin
      step({1'b0,1'b0,XX,1'b0, 1'b0,1'b0,XX,1'b0, 2'b00});
      check("R10", 1'b1, 1'b0);
    end
    // R9: ordinary word reads/writes on both ports
    step({1'b1,1'b1,XX,1'b0, 1'b1,1'b0,12'h000,1'b0, 2'b00});
    check("R9", 1'b1, 1'b0);
    // R7: port 1 reads own box while busy, and port 0 busy too
    step({1'b1,1'b1,LO,1'b1, 1'b1,1'b0,HI,1'b1, 2'b00});
    check("R7", 1'b1, 1'b0);
    // R3 then R1: reset while both asserted
    step({1'b0,1'b0,XX,1'b0, 1'b1,1'b1,LO,1'b0, 2'b00});
    check("R3", 1'b0, 1'b0);
    rst_n = 1'b0;
    step({1'b0,1'b0,XX,1'b0, 1'b0,1'b0,XX,1'b0, 2'b00});
    check("R1", 1'b1, 1'b1);
    // R1: write during reset ignored
    step({1'b1,1'b1,HI,1'b0, 1'b0,1'b0,XX,1'b0, 2'b00});
    check("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    step({1'b0,1'b0,XX,1'b0, 1'b0,1'b0,XX,1'b0, 2'b00});
    check("R1", 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule